// File: doc/BRIEF.md
# Cascaded Banked Interrupt Controller

This block merges a large set of level-sensitive peripheral requests into one processor interrupt line and a resolved source number. The main sources sit in a number of equal-width banks (three banks of 32 by default, 96 sources). Each source is pending when its raw status bit is high and its enable bit is set. Two positions inside the main banks are not ordinary sources but cascade points: one in bank 0 stands for a group of software-triggered interrupts held inside the block, the other in bank 1 stands for an external group whose pending word arrives already aggregated on an input.

Resolution walks the banks in ascending order and, inside a bank, picks the lowest pending index. When a cascade point is pending and its secondary group has a pending bit, the lowest pending bit of that group wins ahead of the rest of that bank; otherwise the walk goes on with the ordinary bits. The result is registered: a small output state machine with the states IDLE (no winner, outputs cleared) and ACTIVE (line high, vector and class held) moves on RAISE (IDLE to ACTIVE when a winner exists), HOLD (ACTIVE to ACTIVE, the vector may change to a new winner) and DROP (ACTIVE to IDLE when nothing is pending). A second, independent set of bank enables drives a second output line.

Software sets enables and software triggers through a simple word-wide write port with a combinational read-back.

Top module: `irqc_cascade`

## Requirements
- R1: A main source is pending only when its status bit and its line-A enable bit are both 1; a main winner is reported with class code 0 and vector bank*32+bit.
- R2: After reset every enable register, the software enable and the software trigger read 0, and the outputs are idle: line A low, line B low, vector 0, class code 3.
- R3: Banks are searched in order 0, 1, 2 and within a bank the lowest pending bit index wins.
- R4: When bank 0 bit 7 is pending and (software trigger AND software enable) is non-zero, the winner has class code 1 and vector equal to the lowest set bit of that word, ahead of every other bank 0 bit.
- R5: When bank 1 bit 8 (source 40) is pending and the external group word is non-zero, the winner has class code 2 and vector equal to its lowest set bit, ahead of other bank 1 bits but behind any bank 0 winner.
- R6: Sources 7 and 40 are never reported as main sources; when a cascade point is pending with an empty secondary group the search continues with the remaining bits of that bank and later banks.
- R7: Register addresses: 0-2 line A enables of banks 0-2, 3-5 line B enables of banks 0-2, 6 software enable, 7 software trigger; a write replaces the full 32-bit word and reads return the stored word.
- R8: A software trigger bit stays set until the trigger register is written again.
- R9: Line B is high one cycle after any status bit meets a set line B enable bit, and low otherwise.
- R10: Line A, vector and class change one clock edge after the status inputs change; line A is high exactly when a winner exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data at reg_addr_i |
| src_status_i | input | 96 | Raw level status of all main sources |
| gpio_pend_i | input | 32 | Aggregated pending word of the external group |
| cpu_irq_o | output | 1 | Line A processor interrupt |
| cpu_irq_b_o | output | 1 | Line B processor interrupt |
| irq_vec_o | output | 7 | Resolved source number |
| irq_cls_o | output | 2 | Class of winner: 0 main, 1 software, 2 external group, 3 none |

## Verification
A wrong enable or trigger register shows at once on the read port and, one edge after its write, as a missing or extra winner on the vector. A wrong priority or cascade mask shows as a wrong vector or class exactly one edge after the status pattern is applied, so every single-source and two-source pattern is checked one cycle after it is driven. A stuck output state shows as a line A level that disagrees with whether any winner exists in that same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        CLS_MAIN = 2'd0,
        CLS_SW   = 2'd1,
        CLS_GPIO = 2'd2,
        CLS_NONE = 2'd3
    } src_class_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } out_state_e;

endpackage

// File: rtl/irqc_lsb_find.sv
module irqc_lsb_find #(
    parameter int W  = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  word_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        hit_o = |word_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (word_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
    parameter int NBANKS = 3,
    parameter int W      = 32,
    localparam int AW    = $clog2(2 * NBANKS + 2)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [W-1:0]        wdata_i,
    output logic [W-1:0]        rdata_o,
    output logic [NBANKS*W-1:0] en_a_o,
    output logic [NBANKS*W-1:0] en_b_o,
    output logic [W-1:0]        sw_en_o,
    output logic [W-1:0]        sw_trig_o
);

    localparam logic [AW-1:0] ADDR_SWEN = AW'(2 * NBANKS);
    localparam logic [AW-1:0] ADDR_TRIG = AW'(2 * NBANKS + 1);

    logic [W-1:0] en_a_q [NBANKS];
    logic [W-1:0] en_b_q [NBANKS];
    logic [W-1:0] sw_en_q;
    logic [W-1:0] sw_trig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int b = 0; b < NBANKS; b++) begin
                en_a_q[b] <= '0;
                en_b_q[b] <= '0;
            end
            sw_en_q   <= '0;
            sw_trig_q <= '0;
        end else if (wr_i) begin
            for (int b = 0; b < NBANKS; b++) begin
                if (addr_i == AW'(b)) begin
                    en_a_q[b] <= wdata_i;
                end
                if (addr_i == AW'(NBANKS + b)) begin
                    en_b_q[b] <= wdata_i;
                end
            end
            if (addr_i == ADDR_SWEN) begin
                sw_en_q <= wdata_i;
            end
            if (addr_i == ADDR_TRIG) begin
                sw_trig_q <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (addr_i == AW'(b)) begin
                rdata_o = en_a_q[b];
            end
            if (addr_i == AW'(NBANKS + b)) begin
                rdata_o = en_b_q[b];
            end
        end
        if (addr_i == ADDR_SWEN) begin
            rdata_o = sw_en_q;
        end
        if (addr_i == ADDR_TRIG) begin
            rdata_o = sw_trig_q;
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_flat
        assign en_a_o[b*W +: W] = en_a_q[b];
        assign en_b_o[b*W +: W] = en_b_q[b];
    end

    assign sw_en_o   = sw_en_q;
    assign sw_trig_o = sw_trig_q;

    // R2: the first edge after reset release sees all enables cleared
    a_r2_enables_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (en_a_o == '0 && en_b_o == '0 && sw_en_q == '0));

    // R8: the trigger word only changes on a write to its address
    a_r8_trigger_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && addr_i == ADDR_TRIG) |=> $stable(sw_trig_q));

endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
    parameter int NBANKS   = 3,
    parameter int W        = 32,
    parameter int SW_POS   = 7,
    parameter int GPIO_POS = 8,
    localparam int IW      = $clog2(W),
    localparam int VW      = $clog2(NBANKS * W)
) (
    input  logic [NBANKS*W-1:0] status_i,
    input  logic [NBANKS*W-1:0] en_a_i,
    input  logic [NBANKS*W-1:0] en_b_i,
    input  logic [W-1:0]        sw_en_i,
    input  logic [W-1:0]        sw_trig_i,
    input  logic [W-1:0]        gpio_i,
    output logic                win_valid_o,
    output logic [VW-1:0]       win_vec_o,
    output irqc_pkg::src_class_e win_cls_o,
    output logic                any_b_o
);

    import irqc_pkg::*;

    logic [NBANKS-1:0] main_hit;
    logic [NBANKS-1:0] casc_hit;
    logic [IW-1:0]     main_idx [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam logic [W-1:0] ONE  = W'(1);
        localparam logic [W-1:0] KEEP = (b == 0) ? ~(ONE << SW_POS) :
                                        (b == 1) ? ~(ONE << GPIO_POS) : '1;
        localparam int CPOS = (b == 0) ? SW_POS : GPIO_POS;

        logic [W-1:0] pend;
        assign pend = status_i[b*W +: W] & en_a_i[b*W +: W];

        if (b < 2) begin : g_casc
            assign casc_hit[b] = pend[CPOS];
        end else begin : g_plain
            assign casc_hit[b] = 1'b0;
        end

        irqc_lsb_find #(.W(W)) u_find (
            .word_i (pend & KEEP),
            .hit_o  (main_hit[b]),
            .idx_o  (main_idx[b])
        );
    end

    logic          sw_hit, gp_hit;
    logic [IW-1:0] sw_idx, gp_idx;

    irqc_lsb_find #(.W(W)) u_find_sw (
        .word_i (sw_trig_i & sw_en_i),
        .hit_o  (sw_hit),
        .idx_o  (sw_idx)
    );

    irqc_lsb_find #(.W(W)) u_find_gpio (
        .word_i (gpio_i),
        .hit_o  (gp_hit),
        .idx_o  (gp_idx)
    );

    always_comb begin
        win_valid_o = 1'b0;
        win_vec_o   = '0;
        win_cls_o   = CLS_NONE;
        for (int b = 0; b < NBANKS; b++) begin
            if (!win_valid_o) begin
                if (b == 0 && casc_hit[b] && sw_hit) begin
                    win_valid_o = 1'b1;
                    win_vec_o   = VW'(sw_idx);
                    win_cls_o   = CLS_SW;
                end else if (b == 1 && casc_hit[b] && gp_hit) begin
                    win_valid_o = 1'b1;
                    win_vec_o   = VW'(gp_idx);
                    win_cls_o   = CLS_GPIO;
                end else if (main_hit[b]) begin
                    win_valid_o = 1'b1;
                    win_vec_o   = VW'(b * W) + VW'(main_idx[b]);
                    win_cls_o   = CLS_MAIN;
                end
            end
        end
    end

    assign any_b_o = |(status_i & en_b_i);

endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade #(
    parameter int NBANKS        = 3,
    parameter int W             = 32,
    parameter int SW_CASC_POS   = 7,
    parameter int GPIO_CASC_SRC = 40,
    localparam int AW           = $clog2(2 * NBANKS + 2),
    localparam int VW           = $clog2(NBANKS * W)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                reg_wr_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic [W-1:0]        reg_wdata_i,
    output logic [W-1:0]        reg_rdata_o,
    input  logic [NBANKS*W-1:0] src_status_i,
    input  logic [W-1:0]        gpio_pend_i,
    output logic                cpu_irq_o,
    output logic                cpu_irq_b_o,
    output logic [VW-1:0]       irq_vec_o,
    output logic [1:0]          irq_cls_o
);

    import irqc_pkg::*;

    localparam int GPIO_POS = GPIO_CASC_SRC % W;

    logic [NBANKS*W-1:0] en_a_w, en_b_w;
    logic [W-1:0]        sw_en_w, sw_trig_w;

    irqc_regs #(.NBANKS(NBANKS), .W(W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .en_a_o    (en_a_w),
        .en_b_o    (en_b_w),
        .sw_en_o   (sw_en_w),
        .sw_trig_o (sw_trig_w)
    );

    logic       win_valid;
    logic [VW-1:0] win_vec;
    src_class_e win_cls;
    logic       any_b;

    irqc_resolve #(
        .NBANKS   (NBANKS),
        .W        (W),
        .SW_POS   (SW_CASC_POS),
        .GPIO_POS (GPIO_POS)
    ) u_resolve (
        .status_i    (src_status_i),
        .en_a_i      (en_a_w),
        .en_b_i      (en_b_w),
        .sw_en_i     (sw_en_w),
        .sw_trig_i   (sw_trig_w),
        .gpio_i      (gpio_pend_i),
        .win_valid_o (win_valid),
        .win_vec_o   (win_vec),
        .win_cls_o   (win_cls),
        .any_b_o     (any_b)
    );

    out_state_e state_q, state_d;
    logic [VW-1:0] vec_q;
    src_class_e    cls_q;
    logic          irq_b_q;

    // next-state: RAISE, HOLD, DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = win_valid ? ST_ACTIVE : ST_IDLE;
            ST_ACTIVE: state_d = win_valid ? ST_ACTIVE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vec_q   <= '0;
            cls_q   <= CLS_NONE;
            irq_b_q <= 1'b0;
        end else begin
            irq_b_q <= any_b;
            unique case (state_d)
                ST_ACTIVE: begin
                    vec_q <= win_vec;
                    cls_q <= win_cls;
                end
                ST_IDLE: begin
                    vec_q <= '0;
                    cls_q <= CLS_NONE;
                end
                default: begin
                    vec_q <= '0;
                    cls_q <= CLS_NONE;
                end
            endcase
        end
    end

    assign cpu_irq_o   = (state_q == ST_ACTIVE);
    assign cpu_irq_b_o = irq_b_q;
    assign irq_vec_o   = vec_q;
    assign irq_cls_o   = cls_q;

    logic [NBANKS*W-1:0] pend_a_w;
    assign pend_a_w = src_status_i & en_a_w;

    // R10: idle outputs carry no vector and no class
    a_r10_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_irq_o |-> (irq_vec_o == '0 && irq_cls_o == CLS_NONE));

    // R6: a cascade position never shows as a main source
    a_r6_cascade_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_irq_o && irq_cls_o == CLS_MAIN) |->
        (irq_vec_o != VW'(SW_CASC_POS) && irq_vec_o != VW'(W + GPIO_POS)));

    // R4: a software winner needs its cascade bit and a live trigger
    a_r4_sw_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_irq_o && irq_cls_o == CLS_SW) |->
        ($past(pend_a_w[SW_CASC_POS]) && $past(|(sw_trig_w & sw_en_w))));

    // R5: an external-group winner needs its cascade bit and a pending word
    a_r5_gpio_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_irq_o && irq_cls_o == CLS_GPIO) |->
        ($past(pend_a_w[W + GPIO_POS]) && $past(|gpio_pend_i)));

    // R1: a main winner implies some enabled status bit one edge earlier
    a_r1_main_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_irq_o && irq_cls_o == CLS_MAIN) |-> $past(|pend_a_w));

    // R9: line B follows its enables with one edge of delay
    a_r9_line_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_irq_b_o |-> $past(|(src_status_i & en_b_w)));

endmodule

// File: tb/irqc_cascade_bench.sv
`timescale 1ns/1ps
module irqc_cascade_bench;

    localparam int NB  = 3;
    localparam int W   = 32;
    localparam int SWC = 7;
    localparam int GPC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [95:0] st = '0;
    logic [31:0] gpio = '0;
    logic        irq, irq_b;
    logic [6:0]  vec;
    logic [1:0]  cls;

    logic [31:0] ea [NB];
    logic [31:0] eb [NB];
    logic [31:0] swen, swtr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    irqc_cascade u_irqc_cascade (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .src_status_i (st),
        .gpio_pend_i  (gpio),
        .cpu_irq_o    (irq),
        .cpu_irq_b_o  (irq_b),
        .irq_vec_o    (vec),
        .irq_cls_o    (cls)
    );

    task automatic chk(input string r, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic void model(output bit v, output int ev, output int ec);
        logic [31:0] word, s;
        v = 0; ev = 0; ec = 3;
        for (int b = 0; b < NB; b++) begin
            word = st[b*32 +: 32] & ea[b];
            if (b == 0 && word[SWC]) begin
                s = swtr & swen;
                for (int i = 0; i < 32; i++)
                    if (!v && s[i]) begin v = 1; ev = i; ec = 1; end
            end
            if (b == 1 && word[GPC]) begin
                for (int i = 0; i < 32; i++)
                    if (!v && gpio[i]) begin v = 1; ev = i; ec = 2; end
            end
            for (int i = 0; i < 32; i++) begin
                if (!v && word[i] && !(b == 0 && i == SWC) && !(b == 1 && i == GPC)) begin
                    v = 1; ev = b * 32 + i; ec = 0;
                end
            end
        end
    endfunction

    task automatic reg_wr(input int a, input logic [31:0] d);
        wr = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
        if (a < 3) ea[a] = d;
        else if (a < 6) eb[a-3] = d;
        else if (a == 6) swen = d;
        else swtr = d;
    endtask

    task automatic rd_chk(input string r, input int a, input logic [31:0] exp);
        addr = 3'(a);
        #1;
        chk(r, rdata, exp);
    endtask

    task automatic out_chk(input string r);
        bit v; int ev, ec;
        @(negedge clk);
        model(v, ev, ec);
        chk(r, irq, v);
        chk(r, vec, ev);
        chk(r, cls, ec);
        chk({r, " line B (R9)"}, irq_b, |(st & {eb[2], eb[1], eb[0]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin ea[b] = '0; eb[b] = '0; end
        swen = '0; swtr = '0;
        st = '1;
        repeat (3) @(negedge clk);
        // R2: idle outputs during reset
        chk("R2 irq", irq, 0); chk("R2 vec", vec, 0);
        chk("R2 cls", cls, 3); chk("R2 irq_b", irq_b, 0);
        rst_n = 1'b1;
        // R1/R2: all status high but nothing enabled
        out_chk("R1 R2 no enables");
        for (int a = 0; a < 8; a++) rd_chk("R2 reset read", a, 0);

        // R7: register map write and read back
        for (int a = 0; a < 8; a++) reg_wr(a, 32'hA5000000 | (32'(a) * 32'h01010101));
        for (int a = 0; a < 8; a++) rd_chk("R7 readback", a, 32'hA5000000 | (32'(a) * 32'h01010101));
        for (int a = 0; a < 8; a++) reg_wr(a, 0);
        st = '0;

        // R1/R3/R6: single-source sweep with all line-A enables set
        for (int b = 0; b < NB; b++) reg_wr(b, '1);
        for (int i = 0; i < 96; i++) begin
            st = 96'd1 << i;
            out_chk((i == 7 || i == 40) ? "R6 lone cascade bit" : "R3 single source");
        end

        // R3: two-source patterns
        for (int i = 0; i < 96; i += 5)
            for (int j = i + 1; j < 96; j += 7) begin
                st = (96'd1 << i) | (96'd1 << j);
                out_chk("R3 pair");
            end

        // R1: enable gating, one enable bit at a time with all status high
        st = '1;
        for (int b = 0; b < NB; b++) reg_wr(b, 0);
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < 32; i += 3) begin
                reg_wr(b, 32'd1 << i);
                out_chk("R1 enable gate");
                reg_wr(b, 0);
            end
        for (int b = 0; b < NB; b++) reg_wr(b, '1);

        // R4: software cascade
        st = (96'd1 << 7) | (96'd1 << 3) | (96'd1 << 50);
        reg_wr(6, '1);
        for (int k = 0; k < 32; k++) begin
            reg_wr(7, (32'd1 << k) | (32'd1 << 31));
            out_chk("R4 software winner");
        end
        reg_wr(7, 0);
        out_chk("R6 empty software group");
        reg_wr(7, 32'h0000_0F00);
        reg_wr(6, 32'h0000_0C00);
        out_chk("R4 software enable mask");
        reg_wr(6, 0);
        out_chk("R4 software disabled");

        // R8: trigger stays set across cycles and status changes
        reg_wr(7, 32'h8001_0040);
        repeat (20) @(negedge clk);
        st = '0;
        repeat (5) @(negedge clk);
        rd_chk("R8 trigger held", 7, 32'h8001_0040);

        // R5: external group cascade
        st = (96'd1 << 40) | (96'd1 << 33) | (96'd1 << 70);
        for (int k = 0; k < 32; k++) begin
            gpio = (32'd1 << k) | 32'h8000_0000;
            out_chk("R5 group winner");
        end
        gpio = 0;
        out_chk("R6 empty group continues");
        gpio = 32'h10;
        st[2] = 1'b1;
        out_chk("R5 bank 0 ahead of group");

        // R9: line B
        for (int b = 0; b < NB; b++) reg_wr(3 + b, 0);
        st = 96'd1 << 65;
        out_chk("R9 line B off");
        reg_wr(5, 32'd2);
        out_chk("R9 line B on");
        reg_wr(5, 32'd1);
        out_chk("R9 line B other bit");

        // R10: output changes one edge after status
        gpio = 0; st = 0; reg_wr(5, 0);
        out_chk("R10 idle");
        st = 96'd1 << 10;
        #1;
        chk("R10 before edge", irq, 0);
        out_chk("R10 after edge");

        // R3/R4/R5: mixed sparse patterns
        reg_wr(6, '1);
        for (int n = 0; n < 400; n++) begin
            st = {rnd() & rnd() & rnd(), rnd() & rnd() & rnd(), rnd() & rnd() & rnd()};
            gpio = rnd() & rnd() & rnd();
            if (n % 16 == 0) reg_wr(7, rnd() & rnd());
            if (n % 32 == 0) reg_wr(n % 3, rnd() | rnd());
            out_chk("R3 mixed pattern");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule